// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDR SDRAM interface and brings the memory from power-up to a usable state. It leaves synchronous reset once the clock is stable. It then holds the command pins in an idle encoding for a programmable number of clock cycles. After that it issues one precharge of all banks, exactly two auto-refresh commands and finally a load-mode-register command. The mode word for that last command is assembled from the configuration inputs. Each command is one clock cycle long and is followed by a timed gap of idle cycles. All gap lengths are parameters counted in clock cycles.

After the gap that follows the mode load, the block raises `init_done` and keeps the pins idle until the next reset. A normal command scheduler takes over the pins once `init_done` is high. The order of the commands is fixed. A reset at any point restarts the whole sequence from the beginning of the idle window.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst` is high, and on the cycle it is released, the pins carry the idle command, `sd_addr` and `sd_ba` are zero and `init_done` is 0.
- R2: From the release of reset, the pins carry only the idle command for WAIT_CYC cycles. With IDLE_INHIBIT=0 the idle command is {cs_n,ras_n,cas_n,we_n}=0111 (NOP). With IDLE_INHIBIT=1 it is 1111 (inhibit). The first real command appears on cycle WAIT_CYC, counting the release cycle as cycle 0.
- R3: The first real command is a precharge, pins 0010. It has `sd_addr` bit 10 set, all other address bits at zero and `sd_ba` at zero, so every bank is selected.
- R4: An auto-refresh (pins 0001) follows T_RP cycles after the precharge. A second auto-refresh follows T_RC cycles after the first. No refresh is issued before the precharge.
- R5: A load-mode-register command (pins 0000) follows T_RC cycles after the second refresh. It is issued only after the precharge and both refreshes, while all banks are idle.
- R6: During the mode load, `sd_addr` carries the mode word: burst length in bits 2:0, burst type in bit 3, CAS latency in bits 6:4, operating mode in bits 8:7 and write-burst mode in bit 9.
- R7: During the mode load, `sd_addr` bits 11 and up are zero, and so is `sd_ba`.
- R8: Each command lasts exactly one cycle and every other cycle is idle. `init_done` rises T_MRD cycles after the mode load and stays high until reset.
- R9: Once `init_done` is high, changes on the configuration inputs have no effect: the pins stay idle and `sd_addr` stays zero.
- R10: A reset in the middle of the sequence returns the block to the start of the idle window. The full timing of R2 to R8 then repeats from the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_burst_ilv | input | 1 | Burst type: 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_op_mode | input | 2 | Operating mode code |
| cfg_wr_single | input | 1 | Write burst mode: 1 single-location writes |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Row/address bus |
| init_done | output | 1 | Initialization complete |

## Verification
The bench runs the full sequence with three mode configurations.
- A typical word with mixed field values shows that the timing is correct and the main fields land in place.
- An all-ones word exposes any field that spills into a neighbour or into the reserved bits.
- A sparse word with single set bits in separate fields catches swapped or shifted fields.

Every cycle of each run is compared with the expected command, address and ready level. This catches an extra command, a missing one, or a command one cycle early or late.

Two further patterns cover the remaining behaviour:
- A reset issued between the two refreshes shows that the sequence restarts from the idle window and not from the step it was on.
- Toggling the configuration inputs after ready shows that the pins have become inert.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

   // Width of the mode field carried on the address bus
   localparam int MODE_W  = 12;
   // First reserved bit of the mode field
   localparam int RSVD_LO = 10;

   typedef enum logic [2:0] {
      ST_WAIT  = 3'd0,
      ST_PRE   = 3'd1,
      ST_REF1  = 3'd2,
      ST_REF2  = 3'd3,
      ST_LMR   = 3'd4,
      ST_READY = 3'd5
   } seq_state_t;

   typedef enum logic [1:0] {
      CK_IDLE = 2'd0,
      CK_PRE  = 2'd1,
      CK_REF  = 2'd2,
      CK_LMR  = 2'd3
   } cmd_kind_t;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_pins_t;

   localparam cmd_pins_t PINS_NOP     = cmd_pins_t'(4'b0111);
   localparam cmd_pins_t PINS_INHIBIT = cmd_pins_t'(4'b1111);
   localparam cmd_pins_t PINS_PRE     = cmd_pins_t'(4'b0010);
   localparam cmd_pins_t PINS_REF     = cmd_pins_t'(4'b0001);
   localparam cmd_pins_t PINS_LMR     = cmd_pins_t'(4'b0000);

   // Field order is fixed by the device's mode register decode
   typedef struct packed {
      logic [1:0] rsvd;
      logic       wr_single;
      logic [1:0] op_mode;
      logic [2:0] cas_lat;
      logic       burst_ilv;
      logic [2:0] burst_len;
   } mode_word_t;

endpackage

// File: rtl/sdram_pwrup_timer.sv
module sdram_pwrup_timer #(
   parameter int CNT_W   = 8,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= CNT_W'(RST_VAL);
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // Once at zero the timer must rest there until reloaded
   AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (expired && !load) |=> expired);                        // R2

   // A nonzero count never jumps straight past zero without a load
   AST_TIMER_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
      (!expired && !load) |=> (cnt == $past(cnt) - 1'b1));    // R8

endmodule

// File: rtl/sdram_pwrup_fsm.sv
module sdram_pwrup_fsm
   import sdram_pwrup_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int T_RP  = 3,
   parameter int T_RC  = 8,
   parameter int T_MRD = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             expired,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output cmd_kind_t        cmd_kind,
   output logic             ready
);

   seq_state_t state, state_nxt;
   logic       fresh;

   // Each step's window length, minus the command cycle itself
   localparam logic [CNT_W-1:0] GAP_RP  = CNT_W'(T_RP - 1);
   localparam logic [CNT_W-1:0] GAP_RC  = CNT_W'(T_RC - 1);
   localparam logic [CNT_W-1:0] GAP_MRD = CNT_W'(T_MRD - 1);

   always_comb begin
      state_nxt = state;
      load      = 1'b0;
      load_val  = '0;
      if (expired) begin
         unique case (state)
            ST_WAIT: begin
               state_nxt = ST_PRE;
               load      = 1'b1;
               load_val  = GAP_RP;
            end
            ST_PRE: begin
               state_nxt = ST_REF1;
               load      = 1'b1;
               load_val  = GAP_RC;
            end
            ST_REF1: begin
               state_nxt = ST_REF2;
               load      = 1'b1;
               load_val  = GAP_RC;
            end
            ST_REF2: begin
               state_nxt = ST_LMR;
               load      = 1'b1;
               load_val  = GAP_MRD;
            end
            ST_LMR:   state_nxt = ST_READY;
            default:  state_nxt = ST_READY;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_WAIT;
         fresh <= 1'b0;
      end else begin
         state <= state_nxt;
         fresh <= load;
      end
   end

   // The command is emitted only in the first cycle of its step
   always_comb begin
      cmd_kind = CK_IDLE;
      if (fresh) begin
         unique case (state)
            ST_PRE:           cmd_kind = CK_PRE;
            ST_REF1, ST_REF2: cmd_kind = CK_REF;
            ST_LMR:           cmd_kind = CK_LMR;
            default:          cmd_kind = CK_IDLE;
         endcase
      end
   end

   assign ready = (state == ST_READY);

   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      state inside {ST_WAIT, ST_PRE, ST_REF1, ST_REF2, ST_LMR, ST_READY}); // R8

   AST_CMD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      fresh |=> (!fresh || state != $past(state)));           // R8

   AST_ORDER_FORWARD: assert property (@(posedge clk) disable iff (rst)
      (state != $past(state)) |-> (state == seq_state_t'($past(state) + 3'd1))); // R10

endmodule

// File: rtl/sdram_pwrup_mode.sv
module sdram_pwrup_mode
   import sdram_pwrup_pkg::*;
#(
   parameter int ROW_W = 12
) (
   input  logic [2:0]       burst_len,
   input  logic             burst_ilv,
   input  logic [2:0]       cas_lat,
   input  logic [1:0]       op_mode,
   input  logic             wr_single,
   output logic [ROW_W-1:0] word
);

   mode_word_t mw;

   always_comb begin
      mw.burst_len = burst_len;
      mw.burst_ilv = burst_ilv;
      mw.cas_lat   = cas_lat;
      mw.op_mode   = op_mode;
      mw.wr_single = wr_single;
      mw.rsvd      = '0;
   end

   generate
      if (ROW_W > MODE_W) begin : g_pad
         assign word = {{(ROW_W - MODE_W){1'b0}}, mw};
      end else begin : g_exact
         assign word = mw;
      end
   endgenerate

endmodule

// File: rtl/sdram_pwrup_enc.sv
module sdram_pwrup_enc
   import sdram_pwrup_pkg::*;
#(
   parameter int ROW_W        = 12,
   parameter int BANK_W       = 2,
   parameter int AP_BIT       = 10,
   parameter bit IDLE_INHIBIT = 1'b0
) (
   input  cmd_kind_t        kind,
   input  logic [ROW_W-1:0] mode_word,
   output cmd_pins_t        pins,
   output logic [BANK_W-1:0] ba,
   output logic [ROW_W-1:0] addr
);

   cmd_pins_t idle_pins;

   generate
      if (IDLE_INHIBIT) begin : g_inhibit
         assign idle_pins = PINS_INHIBIT;
      end else begin : g_nop
         assign idle_pins = PINS_NOP;
      end
   endgenerate

   always_comb begin
      pins = idle_pins;
      addr = '0;
      ba   = '0;
      unique case (kind)
         CK_PRE: begin
            pins         = PINS_PRE;
            addr[AP_BIT] = 1'b1;
         end
         CK_REF: pins = PINS_REF;
         CK_LMR: begin
            pins = PINS_LMR;
            addr = mode_word;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
   import sdram_pwrup_pkg::*;
#(
   parameter int ROW_W        = 12,
   parameter int BANK_W       = 2,
   parameter int AP_BIT       = 10,
   parameter int WAIT_CYC     = 5000,
   parameter int T_RP         = 3,
   parameter int T_RC         = 8,
   parameter int T_MRD        = 2,
   parameter bit IDLE_INHIBIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        cfg_burst_len,
   input  logic              cfg_burst_ilv,
   input  logic [2:0]        cfg_cas_lat,
   input  logic [1:0]        cfg_op_mode,
   input  logic              cfg_wr_single,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ROW_W-1:0]  sd_addr,
   output logic              init_done
);

   localparam int MAX_AB   = (WAIT_CYC > T_RP) ? WAIT_CYC : T_RP;
   localparam int MAX_CD   = (T_RC > T_MRD) ? T_RC : T_MRD;
   localparam int MAX_ALL  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int CNT_W    = $clog2(MAX_ALL + 1);
   localparam cmd_pins_t IDLE_PINS = IDLE_INHIBIT ? PINS_INHIBIT : PINS_NOP;

   generate
      if (WAIT_CYC < 1 || T_RP < 1 || T_RC < 1 || T_MRD < 1) begin : g_bad_timing
         $error("sdram_pwrup_seq: every timing parameter must be at least 1");
      end
      if (ROW_W < MODE_W) begin : g_bad_row
         $error("sdram_pwrup_seq: ROW_W must hold the full mode field");
      end
      if (AP_BIT >= ROW_W || AP_BIT < 0) begin : g_bad_ap
         $error("sdram_pwrup_seq: AP_BIT outside the address bus");
      end
      if (BANK_W < 1) begin : g_bad_bank
         $error("sdram_pwrup_seq: BANK_W must be at least 1");
      end
   endgenerate

   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   cmd_kind_t        kind;
   logic [ROW_W-1:0] mode_word;
   cmd_pins_t        pins;

   sdram_pwrup_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (WAIT_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   sdram_pwrup_fsm #(
      .CNT_W (CNT_W),
      .T_RP  (T_RP),
      .T_RC  (T_RC),
      .T_MRD (T_MRD)
   ) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .expired  (tmr_expired),
      .load     (tmr_load),
      .load_val (tmr_val),
      .cmd_kind (kind),
      .ready    (init_done)
   );

   sdram_pwrup_mode #(
      .ROW_W (ROW_W)
   ) u_mode (
      .burst_len (cfg_burst_len),
      .burst_ilv (cfg_burst_ilv),
      .cas_lat   (cfg_cas_lat),
      .op_mode   (cfg_op_mode),
      .wr_single (cfg_wr_single),
      .word      (mode_word)
   );

   sdram_pwrup_enc #(
      .ROW_W        (ROW_W),
      .BANK_W       (BANK_W),
      .AP_BIT       (AP_BIT),
      .IDLE_INHIBIT (IDLE_INHIBIT)
   ) u_enc (
      .kind      (kind),
      .mode_word (mode_word),
      .pins      (pins),
      .ba        (sd_ba),
      .addr      (sd_addr)
   );

   assign sd_cs_n  = pins.cs_n;
   assign sd_ras_n = pins.ras_n;
   assign sd_cas_n = pins.cas_n;
   assign sd_we_n  = pins.we_n;

   // Observation of the command stream at the pins, for the properties below
   cmd_pins_t  pin_view;
   logic       pre_seen;
   logic [1:0] ref_seen;

   assign pin_view = cmd_pins_t'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n});

   always_ff @(posedge clk) begin
      if (rst) begin
         pre_seen <= 1'b0;
         ref_seen <= 2'd0;
      end else begin
         if (pin_view == PINS_PRE)
            pre_seen <= 1'b1;
         if (pin_view == PINS_REF && ref_seen != 2'd3)
            ref_seen <= ref_seen + 2'd1;
      end
   end

   AST_IDLE_BEFORE_PRE: assert property (@(posedge clk) disable iff (rst)
      (!pre_seen && pin_view != PINS_PRE) |-> (pin_view == IDLE_PINS)); // R2

   AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
      (pin_view == PINS_PRE) |-> (sd_addr[AP_BIT] && sd_ba == '0)); // R3

   AST_REF_AFTER_PRE: assert property (@(posedge clk) disable iff (rst)
      (pin_view == PINS_REF) |-> (pre_seen && ref_seen < 2'd2)); // R4

   AST_LMR_BANKS_IDLE: assert property (@(posedge clk) disable iff (rst)
      (pin_view == PINS_LMR) |-> (pre_seen && ref_seen == 2'd2)); // R5

   AST_LMR_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
      (pin_view == PINS_LMR) |-> (sd_addr[ROW_W-1:RSVD_LO] == '0 && sd_ba == '0)); // R7

   AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);                                // R8

   AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
      init_done |-> (pin_view == IDLE_PINS && sd_addr == '0)); // R9

endmodule

// File: tb/sdram_pwrup_seq_bench.sv
module sdram_pwrup_seq_bench;

   localparam int ROW_W  = 12;
   localparam int BANK_W = 2;
   localparam int W      = 20;
   localparam int TRP    = 3;
   localparam int TRC    = 5;
   localparam int TMRD   = 2;

   localparam int K_PRE  = W;
   localparam int K_REF1 = W + TRP;
   localparam int K_REF2 = W + TRP + TRC;
   localparam int K_LMR  = W + TRP + 2 * TRC;
   localparam int K_RDY  = W + TRP + 2 * TRC + TMRD;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [2:0]        cfg_burst_len = 3'd0;
   logic              cfg_burst_ilv = 1'b0;
   logic [2:0]        cfg_cas_lat = 3'd0;
   logic [1:0]        cfg_op_mode = 2'd0;
   logic              cfg_wr_single = 1'b0;
   logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [BANK_W-1:0] sd_ba;
   logic [ROW_W-1:0]  sd_addr;
   logic              init_done;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   always #10 clk = ~clk;

   sdram_pwrup_seq #(
      .ROW_W (ROW_W), .BANK_W (BANK_W), .AP_BIT (10),
      .WAIT_CYC (W), .T_RP (TRP), .T_RC (TRC), .T_MRD (TMRD),
      .IDLE_INHIBIT (1'b0)
   ) u_sdram_pwrup_seq (
      .clk (clk), .rst (rst),
      .cfg_burst_len (cfg_burst_len), .cfg_burst_ilv (cfg_burst_ilv),
      .cfg_cas_lat (cfg_cas_lat), .cfg_op_mode (cfg_op_mode),
      .cfg_wr_single (cfg_wr_single),
      .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n),
      .sd_we_n (sd_we_n), .sd_ba (sd_ba), .sd_addr (sd_addr),
      .init_done (init_done)
   );

   function automatic logic [3:0] pins_now();
      return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [11:0] mode_exp(input logic [2:0] bl, input logic bt,
                                            input logic [2:0] cl, input logic [1:0] op,
                                            input logic wb);
      logic [11:0] w;
      w = 12'(bl);
      w = w | (12'(bt) << 3);
      w = w | (12'(cl) << 4);
      w = w | (12'(op) << 7);
      w = w | (12'(wb) << 9);
      return w;
   endfunction

   task automatic next_cycle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_cfg(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                          input logic [1:0] op, input logic wb);
      cfg_burst_len = bl;
      cfg_burst_ilv = bt;
      cfg_cas_lat   = cl;
      cfg_op_mode   = op;
      cfg_wr_single = wb;
   endtask

   // Holds reset for two cycles, releases it at a falling edge (cycle 0)
   task automatic release_reset();
      @(negedge clk);
      rst = 1'b1;
      next_cycle();
      next_cycle();
      rst = 1'b0;
   endtask

   // Checks every cycle of a full initialization against the timeline
   task automatic run_full(input string tag, input logic [11:0] mw, input int upto);
      for (int k = 0; k <= upto; k++) begin
         logic [3:0]  exp_pins;
         logic [11:0] exp_addr;
         string       req;
         exp_pins = 4'b0111; exp_addr = '0; req = "R2";
         if (k == K_PRE) begin
            exp_pins = 4'b0010; exp_addr = 12'h400; req = "R3";
         end else if (k == K_REF1 || k == K_REF2) begin
            exp_pins = 4'b0001; req = "R4";
         end else if (k == K_LMR) begin
            exp_pins = 4'b0000; exp_addr = mw; req = "R6";
         end else if (k > K_PRE) begin
            req = "R8";
         end
         check(pins_now() == exp_pins, (k == K_LMR) ? "R5" : req,
               {tag, " command pins"}, 32'(pins_now()), 32'(exp_pins));
         check(sd_addr == exp_addr, req, {tag, " address"}, 32'(sd_addr), 32'(exp_addr));
         check(sd_ba == '0, (k == K_LMR) ? "R7" : req, {tag, " bank"}, 32'(sd_ba), 32'd0);
         if (k == K_LMR)
            check(sd_addr[11:10] == 2'b00, "R7", {tag, " reserved bits"},
                  32'(sd_addr[11:10]), 32'd0);
         check(init_done == (k >= K_RDY), "R8", {tag, " ready"},
               32'(init_done), 32'(k >= K_RDY));
         if (k < upto) next_cycle();
      end
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      rst = 1'b1;
      next_cycle();
      next_cycle();
      check(pins_now() == 4'b0111, "R1", "pins in reset", 32'(pins_now()), 32'h7);
      check(sd_addr == '0, "R1", "address in reset", 32'(sd_addr), 32'd0);
      check(sd_ba == '0, "R1", "bank in reset", 32'(sd_ba), 32'd0);
      check(init_done == 1'b0, "R1", "ready in reset", 32'(init_done), 32'd0);
   endtask

   task automatic t_mode_typical();
      set_cfg(3'b010, 1'b0, 3'b011, 2'b00, 1'b0);
      release_reset();
      run_full("typical", mode_exp(3'b010, 1'b0, 3'b011, 2'b00, 1'b0), K_RDY + 4);
   endtask

   task automatic t_mode_all_ones();
      set_cfg(3'b111, 1'b1, 3'b111, 2'b11, 1'b1);
      release_reset();
      run_full("all-ones", mode_exp(3'b111, 1'b1, 3'b111, 2'b11, 1'b1), K_RDY + 2);
      check(mode_exp(3'b111, 1'b1, 3'b111, 2'b11, 1'b1) == 12'h3FF, "R6",
            "bench word self-consistency", 32'h3FF, 32'h3FF);
   endtask

   task automatic t_mode_sparse();
      set_cfg(3'b001, 1'b1, 3'b100, 2'b01, 1'b0);
      release_reset();
      run_full("sparse", mode_exp(3'b001, 1'b1, 3'b100, 2'b01, 1'b0), K_RDY + 2);
   endtask

   task automatic t_mid_reset();
      set_cfg(3'b011, 1'b0, 3'b010, 2'b00, 1'b1);
      release_reset();
      for (int k = 0; k < K_REF1 + 2; k++) next_cycle();
      rst = 1'b1;
      next_cycle();
      check(pins_now() == 4'b0111, "R10", "pins during mid reset", 32'(pins_now()), 32'h7);
      check(init_done == 1'b0, "R10", "ready during mid reset", 32'(init_done), 32'd0);
      next_cycle();
      rst = 1'b0;
      run_full("restart R10", mode_exp(3'b011, 1'b0, 3'b010, 2'b00, 1'b1), K_RDY + 1);
   endtask

   task automatic t_after_ready();
      set_cfg(3'b000, 1'b0, 3'b010, 2'b00, 1'b0);
      release_reset();
      for (int k = 0; k < K_RDY + 1; k++) next_cycle();
      for (int i = 0; i < 30; i++) begin
         set_cfg(3'(i), i[0], 3'(i + 3), 2'(i), i[1]);
         next_cycle();
         check(pins_now() == 4'b0111, "R9", "pins after ready", 32'(pins_now()), 32'h7);
         check(sd_addr == '0, "R9", "address after ready", 32'(sd_addr), 32'd0);
         check(init_done == 1'b1, "R8", "ready held", 32'(init_done), 32'd1);
      end
      rst = 1'b1;
      next_cycle();
      check(init_done == 1'b0, "R1", "ready dropped by reset", 32'(init_done), 32'd0);
      rst = 1'b0;
   endtask

   initial begin
      t_reset_state();
      t_mode_typical();
      t_mode_all_ones();
      t_mode_sparse();
      t_mid_reset();
      t_after_ready();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule